// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Trap Levels

This block decides which interrupt a CPU core should take next. It serves a set of user sources and a small set of trap sources. Each user source holds a pending flag, an enable bit and a 3-bit priority. Hardware pulses set the flags and software changes them through a simple register port. Trap sources carry fixed levels from 8 upward, each with its own status flag. The block keeps the current CPU priority level and presents a request, a vector index and the request's level. When the core accepts a request, the block raises the CPU level and saves the old one on an internal stack. A return pulse restores the saved level.

Two further controls shape arbitration. A counted disable window masks user levels 1 to 6 for a programmed number of cycles and leaves level 7 and traps alone. A nesting-disable bit stops any new user interrupt while one is in service.

Register map (address, content): 0..N_SRC-1 hold one word per user source, with bit 0 the flag, bit 1 the enable and bits 4:2 the priority. N_SRC holds the trap flags, one bit per trap, write-1-to-clear. N_SRC+1 holds the CPU level, written from bits 2:0 and read as 4 bits. N_SRC+2 holds the nesting-disable bit in bit 0. N_SRC+3 holds the disable-window count: a write loads it, and a read returns the cycles left.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every user priority field reads 4, every enable and flag reads 0, every trap flag reads 0, the CPU level is 0 and irq_o is low.
- R2: A user source requests only when its flag, its enable and a non-zero priority are all set. Priority 0 never requests.
- R3: Among requesting user sources the highest priority wins, and on a tie the lowest index wins. Trap j has vector j, and user source i has vector N_TRAP+i.
- R4: A source is taken only when its level is strictly above the CPU level, so a CPU level of 7 masks every user source.
- R5: Trap j has level 8+j and beats any user source. Neither the disable window nor nesting-disable masks it, and the highest pending trap above the CPU level wins.
- R6: Writing count C to the window register masks user levels 1 to 6 for exactly C cycles. Level 7 sources still request during the window.
- R7: With nesting-disable set and at least one level saved on the stack, no user source requests.
- R8: An accept pulse while irq_o is high and the stack is not full pushes the CPU level, sets the CPU level to irq_lvl_o and drives irq_o low in the next cycle. An accept pulse while irq_o is low, or while the stack is full, has no effect.
- R9: A return pulse pops the stack into the CPU level. It is ignored when the stack is empty or when an accept happens in the same cycle. A CPU-level write is ignored in a cycle with an accept or a return.
- R10: Flags stay set until software clears them, so an uncleared source is taken again after return. Trap flags clear by writing 1. A hardware set in the same cycle as a clear leaves the flag set.
- R11: irq_o, irq_vec_o and irq_lvl_o are registered. They reflect flags, enables, priorities, CPU level and controls one cycle after those change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| src_set_i | input | N_SRC | Hardware flag set, one per user source |
| trap_set_i | input | N_TRAP | Trap flag set, one per trap |
| irq_ack_i | input | 1 | CPU accepts the presented request |
| irq_ret_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request to CPU |
| irq_vec_o | output | VW | Vector index of the request |
| irq_lvl_o | output | 4 | Level of the request |
| cpu_lvl_o | output | 4 | Current CPU priority level |

## Verification
A change to flags, enables, priorities, CPU level or controls appears on the request outputs one rising edge later. An accept or return moves the CPU level on the same edge, and the request outputs follow one edge after that. The disable window covers exactly the C edges after the write. The bench drives inputs and compares every output at the falling edge, where registered results are settled. The comparison is against a behavioural model updated at each rising edge, and directed checks sample at the falling edge after the edge that the requirement names.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t TRAP_BASE = 4'd8;
  localparam logic [2:0] PRIO_RST = 3'd4;
  localparam logic [2:0] PRIO_TOP = 3'd7;

  typedef struct packed {
    logic [2:0] prio;
    logic       en;
    logic       flag;
  } src_reg_t;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       we_i,
  input  src_reg_t               wdata_i,
  input  logic [N_SRC-1:0]       set_i,
  output src_reg_t [N_SRC-1:0]   regs_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= '{prio: PRIO_RST, en: 1'b0, flag: 1'b0};
      end else begin
        if (we_i[i]) begin
          regs_o[i].prio <= wdata_i.prio;
          regs_o[i].en   <= wdata_i.en;
        end
        // hardware set wins over a software clear
        regs_o[i].flag <= set_i[i] | (we_i[i] ? wdata_i.flag : regs_o[i].flag);
      end
    end

    assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs_o[i].flag && !we_i[i]) |=> regs_o[i].flag);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 4,
  parameter int VW     = 4
) (
  input  src_reg_t [N_SRC-1:0] regs_i,
  input  logic [N_TRAP-1:0]    trap_i,
  input  lvl_t                 cpu_lvl_i,
  input  logic                 win_act_i,
  input  logic                 nest_blk_i,
  output logic                 req_o,
  output logic [VW-1:0]        vec_o,
  output lvl_t                 lvl_o
);
  lvl_t best;
  logic elig;

  always_comb begin
    req_o = 1'b0;
    vec_o = '0;
    best  = '0;
    elig  = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      elig = regs_i[i].flag && regs_i[i].en && (regs_i[i].prio != 3'd0)
          && ({1'b0, regs_i[i].prio} > cpu_lvl_i)
          && !(win_act_i && regs_i[i].prio != PRIO_TOP)
          && !nest_blk_i;
      // strict compare keeps the lowest index on ties
      if (elig && {1'b0, regs_i[i].prio} > best) begin
        best  = {1'b0, regs_i[i].prio};
        vec_o = VW'(N_TRAP + i);
        req_o = 1'b1;
      end
    end
    for (int j = 0; j < N_TRAP; j++) begin
      if (trap_i[j] && lvl_t'(TRAP_BASE + lvl_t'(j)) > cpu_lvl_i) begin
        best  = lvl_t'(TRAP_BASE + lvl_t'(j));
        vec_o = VW'(j);
        req_o = 1'b1;
      end
    end
    lvl_o = best;
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  lvl_t       new_lvl_i,
  input  logic       pop_i,
  input  logic       wr_i,
  input  logic [2:0] wr_lvl_i,
  output lvl_t       cpu_lvl_o,
  output logic       full_o,
  output logic       busy_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t           stk_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] sp_m1;
  logic [IW-1:0]  wr_idx, rd_idx;

  assign sp_m1  = sp_q - SPW'(1);
  assign wr_idx = sp_q[IW-1:0];
  assign rd_idx = sp_m1[IW-1:0];
  assign full_o = (sp_q == SPW'(DEPTH));
  assign busy_o = (sp_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q      <= '0;
      cpu_lvl_o <= '0;
      for (int k = 0; k < DEPTH; k++) stk_q[k] <= '0;
    end else if (push_i && !full_o) begin
      stk_q[wr_idx] <= cpu_lvl_o;
      sp_q          <= sp_q + SPW'(1);
      cpu_lvl_o     <= new_lvl_i;
    end else if (pop_i && busy_o) begin
      sp_q      <= sp_m1;
      cpu_lvl_o <= stk_q[rd_idx];
    end else if (wr_i) begin
      cpu_lvl_o <= {1'b0, wr_lvl_i};
    end
  end

  assert_sp_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SPW'(DEPTH));
  assert_push_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (cpu_lvl_o == $past(new_lvl_i)));
  assert_ret_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && busy_o) |=> (cpu_lvl_o == $past(stk_q[rd_idx])));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int N_TRAP    = 4,
  parameter int STK_DEPTH = 8,
  parameter int WIN_W     = 8,
  parameter int DW        = 8,
  localparam int AW       = $clog2(N_SRC + 4),
  localparam int VW       = $clog2(N_SRC + N_TRAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [N_SRC-1:0]  src_set_i,
  input  logic [N_TRAP-1:0] trap_set_i,
  input  logic              irq_ack_i,
  input  logic              irq_ret_i,
  output logic              irq_o,
  output logic [VW-1:0]     irq_vec_o,
  output logic [3:0]        irq_lvl_o,
  output logic [3:0]        cpu_lvl_o
);
  localparam logic [AW-1:0] A_TRAP = AW'(N_SRC);
  localparam logic [AW-1:0] A_CPU  = AW'(N_SRC + 1);
  localparam logic [AW-1:0] A_NEST = AW'(N_SRC + 2);
  localparam logic [AW-1:0] A_WIN  = AW'(N_SRC + 3);

  src_reg_t [N_SRC-1:0] regs;
  logic [N_SRC-1:0]     src_we;
  logic [N_TRAP-1:0]    trap_q;
  logic [WIN_W-1:0]     win_q;
  logic                 nest_q;
  logic                 full, busy, ack_ok;
  logic                 req;
  logic [VW-1:0]        vec;
  lvl_t                 lvl;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) src_we[i] = reg_we_i && (reg_addr_i == AW'(i));
  end

  irq_src_regs #(.N_SRC(N_SRC)) u_src (
    .clk_i, .rst_ni,
    .we_i   (src_we),
    .wdata_i(src_reg_t'(reg_wdata_i[4:0])),
    .set_i  (src_set_i),
    .regs_o (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= '0;
      nest_q <= 1'b0;
      win_q  <= '0;
    end else begin
      trap_q <= (trap_q & ~((reg_we_i && reg_addr_i == A_TRAP) ? reg_wdata_i[N_TRAP-1:0]
                                                               : '0)) | trap_set_i;
      if (reg_we_i && reg_addr_i == A_NEST) nest_q <= reg_wdata_i[0];
      if (reg_we_i && reg_addr_i == A_WIN) win_q <= reg_wdata_i[WIN_W-1:0];
      else if (win_q != '0)                win_q <= win_q - WIN_W'(1);
    end
  end

  irq_arbiter #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .VW(VW)) u_arb (
    .regs_i    (regs),
    .trap_i    (trap_q),
    .cpu_lvl_i (cpu_lvl_o),
    .win_act_i (win_q != '0),
    .nest_blk_i(nest_q && busy),
    .req_o     (req),
    .vec_o     (vec),
    .lvl_o     (lvl)
  );

  assign ack_ok = irq_ack_i && irq_o && !full;

  irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk_i, .rst_ni,
    .push_i   (ack_ok),
    .new_lvl_i(irq_lvl_o),
    .pop_i    (irq_ret_i),
    .wr_i     (reg_we_i && reg_addr_i == A_CPU),
    .wr_lvl_i (reg_wdata_i[2:0]),
    .cpu_lvl_o(cpu_lvl_o),
    .full_o   (full),
    .busy_o   (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
      irq_lvl_o <= '0;
    end else begin
      irq_o     <= req && !ack_ok; // squash the stale request on accept
      irq_vec_o <= vec;
      irq_lvl_o <= lvl;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (reg_addr_i == AW'(i)) reg_rdata_o = DW'(regs[i]);
    case (reg_addr_i)
      A_TRAP:  reg_rdata_o = DW'(trap_q);
      A_CPU:   reg_rdata_o = DW'(cpu_lvl_o);
      A_NEST:  reg_rdata_o = DW'(nest_q);
      A_WIN:   reg_rdata_o = DW'(win_q);
      default: ;
    endcase
  end

  assert_lvl_above_cpu_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o > $past(cpu_lvl_o)));
  assert_ack_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok |=> !irq_o);
  assert_win_lvl7_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(win_q) != '0) |-> (irq_lvl_o >= 4'd7));
  assert_nest_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(nest_q && busy)) |-> (irq_lvl_o >= 4'd8));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NS = 8, NT = 4, DEP = 8;
  localparam int A_TRAP = NS, A_CPU = NS + 1, A_NEST = NS + 2, A_WIN = NS + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, ack = 0, reti = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NS-1:0] src = 0;
  logic [NT-1:0] trap = 0;
  logic irq;
  logic [3:0] vec, lvl, cpu;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .src_set_i(src), .trap_set_i(trap), .irq_ack_i(ack),
    .irq_ret_i(reti), .irq_o(irq), .irq_vec_o(vec), .irq_lvl_o(lvl), .cpu_lvl_o(cpu)
  );

  // behavioural reference model
  int m_fl[NS], m_en[NS], m_pr[NS], m_tf[NT];
  int m_cpu, m_nest, m_win, m_irq, m_vec, m_lvl;
  int m_stk[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_fl[i] = 0; m_en[i] = 0; m_pr[i] = 4; end
      for (int j = 0; j < NT; j++) m_tf[j] = 0;
      m_cpu = 0; m_nest = 0; m_win = 0; m_irq = 0; m_vec = 0; m_lvl = 0;
      m_stk.delete();
    end else begin
      int w_irq, w_vec, w_lvl, acc;
      w_irq = 0; w_vec = 0; w_lvl = 0;
      for (int i = 0; i < NS; i++)
        if (m_fl[i] && m_en[i] && m_pr[i] > 0 && m_pr[i] > m_cpu &&
            !(m_win > 0 && m_pr[i] < 7) && !(m_nest && m_stk.size() > 0) && m_pr[i] > w_lvl) begin
          w_irq = 1; w_vec = NT + i; w_lvl = m_pr[i];
        end
      for (int j = NT - 1; j >= 0; j--)
        if (m_tf[j] && 8 + j > m_cpu && w_lvl < 8) begin
          w_irq = 1; w_vec = j; w_lvl = 8 + j;
        end
      acc = ack && m_irq && m_stk.size() < DEP;
      if (acc) begin m_stk.push_back(m_cpu); m_cpu = m_lvl; end
      else if (reti && m_stk.size() > 0) m_cpu = m_stk.pop_back();
      else if (we && addr == A_CPU) m_cpu = wdata[2:0];
      if (we && addr < NS) begin
        m_fl[addr] = wdata[0]; m_en[addr] = wdata[1]; m_pr[addr] = wdata[4:2];
      end
      if (we && addr == A_TRAP) for (int j = 0; j < NT; j++) if (wdata[j]) m_tf[j] = 0;
      if (we && addr == A_NEST) m_nest = wdata[0];
      if (we && addr == A_WIN) m_win = wdata;
      else if (m_win > 0) m_win--;
      for (int i = 0; i < NS; i++) if (src[i]) m_fl[i] = 1;
      for (int j = 0; j < NT; j++) if (trap[j]) m_tf[j] = 1;
      m_irq = acc ? 0 : w_irq; m_vec = w_vec; m_lvl = w_lvl;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R11 irq_o vs model", irq, m_irq);
    if (m_irq) begin
      chk("R3 irq_vec_o vs model", vec, m_vec);
      chk("R3 irq_lvl_o vs model", lvl, m_lvl);
    end
    chk("R8 cpu_lvl_o vs model", cpu, m_cpu);
    we = 0; ack = 0; reti = 0; src = 0; trap = 0;
  endtask

  task automatic wr(int a, int d);
    we = 1; addr = a[3:0]; wdata = d[7:0];
    step();
  endtask

  task automatic rd(int a, int exp, string tag);
    addr = a[3:0];
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    rd(0, 16, "R1 src0 reset word");
    rd(NS - 1, 16, "R1 last src reset word");
    rd(A_TRAP, 0, "R1 trap flags reset");
    chk("R1 irq low", irq, 0);
    chk("R1 cpu level", cpu, 0);
    // R8 accept with no request is ignored
    ack = 1; step();
    chk("R8 ack without irq", cpu, 0);
    // R2 enable without flag, priority 0 with flag
    wr(0, 18); step();
    chk("R2 no flag no irq", irq, 0);
    wr(3, 3); step(); step();
    chk("R2 prio0 no irq", irq, 0);
    wr(3, 0);
    // R11 latency from flag set
    src = 1; step();
    chk("R11 irq not yet", irq, 0);
    step();
    chk("R11 irq after one cycle", irq, 1);
    chk("R3 vec src0", vec, NT + 0);
    chk("R3 lvl src0", lvl, 4);
    // R3 tie and higher priority
    wr(1, 19); step(); step();
    chk("R3 tie lowest index", vec, NT + 0);
    wr(2, 27); step(); step();
    chk("R3 highest vec", vec, NT + 2);
    chk("R3 highest lvl", lvl, 6);
    // R4 strict compare with CPU level
    wr(A_CPU, 7); step(); step();
    chk("R4 cpu7 masks all", irq, 0);
    wr(A_CPU, 6); step(); step();
    chk("R4 equal level masked", irq, 0);
    wr(A_CPU, 5); step(); step();
    chk("R4 above level taken", irq, 1);
    wr(A_CPU, 0); step(); step();
    // R8 accept
    ack = 1; step();
    chk("R8 cpu raised", cpu, 6);
    chk("R8 irq dropped", irq, 0);
    step();
    chk("R8 nothing above 6", irq, 0);
    // R7 nesting disable
    wr(A_NEST, 1);
    wr(3, 31); step(); step();
    chk("R7 nested blocked", irq, 0);
    wr(A_NEST, 0); step(); step();
    chk("R7 nest off irq", irq, 1);
    chk("R7 nest off vec", vec, NT + 3);
    ack = 1; step();
    chk("R8 cpu 7", cpu, 7);
    // R5 trap through nesting disable
    wr(A_NEST, 1);
    trap = 1; step(); step();
    chk("R5 trap irq", irq, 1);
    chk("R5 trap vec", vec, 0);
    chk("R5 trap lvl", lvl, 8);
    ack = 1; step();
    chk("R5 cpu 8", cpu, 8);
    wr(A_TRAP, 1);
    rd(A_TRAP, 0, "R10 trap w1c");
    // R9 returns
    reti = 1; step();
    chk("R9 restore 7", cpu, 7);
    reti = 1; step();
    chk("R9 restore 6", cpu, 6);
    reti = 1; step();
    chk("R9 restore 0", cpu, 0);
    step();
    chk("R10 retaken irq", irq, 1);
    chk("R10 retaken vec", vec, NT + 3);
    wr(A_NEST, 0);
    reti = 1; step();
    chk("R9 empty pop ignored", cpu, 0);
    // R10 clear and set collision
    wr(3, 30); step(); step();
    chk("R10 cleared src3 vec", vec, NT + 2);
    src = 4; wr(2, 26);
    rd(2, 27, "R10 set wins over clear");
    // R6 disable window
    wr(A_WIN, 5);
    chk("R6 irq before window", irq, 1);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R6 masked in window", irq, 0);
    end
    step();
    chk("R6 window over", irq, 1);
    wr(A_WIN, 20);
    wr(3, 31); step();
    chk("R6 level7 in window", irq, 1);
    chk("R6 level7 vec", vec, NT + 3);
    wr(3, 30); wr(A_WIN, 0);
    // R8 full stack
    wr(1, 18); wr(2, 18);
    for (int k = 1; k <= 7; k++) begin
      wr(k - 1, k * 4 + 3); step();
      ack = 1; step();
      chk("R8 nest push level", cpu, k);
    end
    trap = 1; step(); step();
    ack = 1; step();
    chk("R8 trap push", cpu, 8);
    trap = 2; step(); step();
    chk("R5 trap1 vec", vec, 1);
    chk("R5 trap1 lvl", lvl, 9);
    ack = 1; step();
    chk("R8 full ack ignored cpu", cpu, 8);
    chk("R8 full ack ignored irq", irq, 1);
    wr(A_TRAP, 3);
    // R9 same-cycle accept and return: accept wins
    for (int k = 0; k < DEP; k++) begin reti = 1; step(); end
    chk("R9 unwound", cpu, 0);
    step();
    ack = 1; reti = 1; step();
    chk("R9 ack beats reti", cpu, 7);
    reti = 1; wdata = 3; we = 1; addr = A_CPU; step();
    chk("R9 pop beats cpu write", cpu, 0);
    repeat (3) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule